// File: doc/BRIEF.md
# Qualified Cache-Slice Event Counter

This block is one programmable performance counter placed next to a cache slice. Each clock cycle the slice presents a small set of event lanes. Each lane carries four things: a valid flag, a class flag that tells a lookup from a snoop response, an outcome code, and an origin code. A configuration register holds an event select, a unit mask, a threshold, an invert bit, an edge bit and an enable bit. The block compares every valid lane against the select and the mask and counts the lanes that match. It then qualifies that count with the threshold, invert and edge settings and adds the result to a 48-bit counter.

Software reads the counter at any time from a plain output. It preloads the counter through a write strobe. A configuration write takes effect from the cycle after the write. Events presented in a cycle appear in the counter value after the next rising clock edge.

Top module: `slice_event_counter`

## Requirements
- R1: While reset is asserted, and after it is released, the counter reads 0 and the configuration is cleared, with enable low. Until software writes a configuration, no event changes the counter.
- R2: With select 0x34, a valid lookup lane matches when its outcome bit is set in the mask and its origin passes the filter. The outcome codes are 0=M, 1=E, 2=S and 3=I, and they map to mask bits 0, 1, 2 and 3. The origin filter bits are bit 4 for a read (origin 0), bit 5 for a write (origin 1) and bit 6 for an external snoop (origin 2). Bit 7 accepts any origin, including origin 3. When mask bits 7:4 are all zero, every origin passes.
- R3: With select 0x34, a mask whose bits 3:0 are all zero matches no lane, whatever its filter bits hold.
- R4: With select 0x22, a valid snoop lane matches when its outcome is in the range 0..4 and mask bit number outcome is set. The outcomes are 0=miss, 1=invalidate clean, 2=hit clean, 3=hit modified and 4=invalidate modified. The lane must also pass the origin filter: bit 5 for external (origin 0), bit 6 for core request (origin 1) and bit 7 for eviction (origin 2). When mask bits 7:5 are all zero, every origin passes. Outcomes 5..7 never match.
- R5: Any other select matches no lane. A lane also matches nothing when its class differs from the select, or when its valid flag is low.
- R6: With threshold 0 and enable high, the counter adds the number of matching lanes each cycle. Invert and edge then have no effect.
- R7: With a nonzero threshold, and with invert and edge low, the counter adds 1 in each cycle where the match count is at least the threshold, and adds 0 otherwise.
- R8: With a nonzero threshold and invert high, the counter adds 1 in each cycle where the match count is below the threshold.
- R9: With a nonzero threshold and edge high, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. The condition counts as false in any cycle where enable was low.
- R10: With enable low, events leave the counter unchanged.
- R11: A counter write loads the written value on the next edge. It wins over any increment in the same cycle.
- R12: The counter wraps from 2^48-1 to 0 without any other effect.
- R13: In the cycle of a configuration write, counting still uses the old configuration. The new settings apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Load the configuration fields below |
| cfgEnable | input | 1 | Global count enable |
| cfgEventSel | input | 8 | Event select code |
| cfgUnitMask | input | 8 | Unit mask (outcome and origin bits) |
| cfgThresh | input | THRESH_W | Per-cycle count threshold, 0 = raw counting |
| cfgInvert | input | 1 | Flip the threshold comparison |
| cfgEdge | input | 1 | Count only rising edges of the condition |
| cntWe | input | 1 | Preload the counter |
| cntWrData | input | CNT_W | Preload value |
| laneValid | input | LANES | Per-lane valid |
| laneIsSnoop | input | LANES | Per-lane class, 1 = snoop response, 0 = lookup |
| laneOutcome | input | 3*LANES | Per-lane outcome code, lane i at bits 3i+2:3i |
| laneOrigin | input | 2*LANES | Per-lane origin code, lane i at bits 2i+1:2i |
| cntValue | output | CNT_W | Current counter value |

## Verification
The properties assume that reset is held for at least one edge before any other input is trusted, and that the unit mask, threshold and mode bits change only through a configuration write. The increment bounds are therefore tied to the registered configuration, never to the raw configuration ports. They also assume that at most LANES events can match in one cycle, which holds because each lane reports at most one event. The stimulus drives every input on the falling edge, so it always meets these conditions. It sweeps every mask value against every outcome and origin code of both classes, and every threshold, invert and edge setting against a fixed sequence of match counts. It also covers the preload, wrap, enable and configuration-timing cases.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam logic [7:0] SEL_LOOKUP = 8'h34;
  localparam logic [7:0] SEL_SNOOP  = 8'h22;

  // Strobes from control to datapath; load has priority over both adds.
  typedef struct packed {
    logic load;
    logic addRaw;
    logic addOne;
  } cnt_strobe_t;
endpackage

// File: rtl/evt_lane_match.sv
module evt_lane_match (
  input  logic [7:0] evtSel,
  input  logic [7:0] unitMask,
  input  logic       valid,
  input  logic       isSnoop,
  input  logic [2:0] outcome,
  input  logic [1:0] origin,
  output logic       hit
);
  import evt_pkg::*;

  logic lkState, lkOrigin, snState, snOrigin;

  always_comb begin
    // Lookup: outcome picks a state bit in mask[3:0]
    lkState = (outcome < 3'd4) && unitMask[outcome[1:0]];
    // Lookup origin filter, mask[7] accepts anything
    if (unitMask[7:4] == 4'b0) begin
      lkOrigin = 1'b1;
    end else begin
      lkOrigin = unitMask[7] ||
                 (origin == 2'd0 && unitMask[4]) ||
                 (origin == 2'd1 && unitMask[5]) ||
                 (origin == 2'd2 && unitMask[6]);
    end
    // Snoop: outcome 0..4 picks mask[4:0]
    snState = (outcome < 3'd5) && unitMask[outcome];
    if (unitMask[7:5] == 3'b0) begin
      snOrigin = 1'b1;
    end else begin
      snOrigin = (origin == 2'd0 && unitMask[5]) ||
                 (origin == 2'd1 && unitMask[6]) ||
                 (origin == 2'd2 && unitMask[7]);
    end

    hit = 1'b0;
    if (valid) begin
      if (!isSnoop && evtSel == SEL_LOOKUP) hit = lkState && lkOrigin;
      if ( isSnoop && evtSel == SEL_SNOOP)  hit = snState && snOrigin;
    end
  end
endmodule

// File: rtl/evt_datapath.sv
module evt_datapath #(
  parameter int LANES = 4,
  parameter int CNT_W = 48,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [7:0]               evtSel,
  input  logic [7:0]               unitMask,
  input  logic [LANES-1:0]         laneValid,
  input  logic [LANES-1:0]         laneIsSnoop,
  input  logic [3*LANES-1:0]       laneOutcome,
  input  logic [2*LANES-1:0]       laneOrigin,
  input  evt_pkg::cnt_strobe_t     strobe,
  input  logic [CNT_W-1:0]         wrData,
  output logic [CW-1:0]            matchCount,
  output logic [CNT_W-1:0]         cntValue
);
  logic [LANES-1:0] laneHit;
  logic [CNT_W-1:0] cntQ;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    evt_lane_match u_match (
      .evtSel  (evtSel),
      .unitMask(unitMask),
      .valid   (laneValid[g]),
      .isSnoop (laneIsSnoop[g]),
      .outcome (laneOutcome[3*g +: 3]),
      .origin  (laneOrigin[2*g +: 2]),
      .hit     (laneHit[g])
    );
  end

  always_comb begin
    matchCount = '0;
    for (int i = 0; i < LANES; i++) matchCount = matchCount + CW'(laneHit[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.load)   cntQ <= wrData;
    else if (strobe.addRaw) cntQ <= cntQ + CNT_W'(matchCount);
    else if (strobe.addOne) cntQ <= cntQ + CNT_W'(1);
  end

  assign cntValue = cntQ;
endmodule

// File: rtl/evt_control.sv
module evt_control #(
  parameter int LANES    = 4,
  parameter int THRESH_W = 3,
  localparam int CW      = $clog2(LANES + 1),
  localparam int CMP_W   = (CW > THRESH_W) ? CW : THRESH_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic                 cfgEnable,
  input  logic [7:0]           cfgEventSel,
  input  logic [7:0]           cfgUnitMask,
  input  logic [THRESH_W-1:0]  cfgThresh,
  input  logic                 cfgInvert,
  input  logic                 cfgEdge,
  input  logic                 cntWe,
  input  logic [CW-1:0]        matchCount,
  output logic                 enQ,
  output logic [7:0]           selQ,
  output logic [7:0]           maskQ,
  output logic [THRESH_W-1:0]  thrQ,
  output logic                 invQ,
  output logic                 edgeQ,
  output logic                 prevCondQ,
  output evt_pkg::cnt_strobe_t strobe
);
  logic thrActive, cond, fire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= 1'b0; selQ <= '0; maskQ <= '0; thrQ <= '0; invQ <= 1'b0; edgeQ <= 1'b0;
    end else if (cfgWe) begin
      enQ <= cfgEnable; selQ <= cfgEventSel; maskQ <= cfgUnitMask;
      thrQ <= cfgThresh; invQ <= cfgInvert; edgeQ <= cfgEdge;
    end
  end

  always_comb begin
    thrActive = (thrQ != '0);
    cond      = thrActive && ((CMP_W'(matchCount) >= CMP_W'(thrQ)) ^ invQ);
    fire      = edgeQ ? (cond && !prevCondQ) : cond;
    strobe.load   = cntWe;
    strobe.addRaw = enQ && !thrActive;
    strobe.addOne = enQ && fire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevCondQ <= 1'b0;
    else       prevCondQ <= enQ && cond;
  end
endmodule

// File: rtl/slice_event_counter.sv
module slice_event_counter #(
  parameter int LANES    = 4,
  parameter int CNT_W    = 48,
  parameter int THRESH_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic                 cfgEnable,
  input  logic [7:0]           cfgEventSel,
  input  logic [7:0]           cfgUnitMask,
  input  logic [THRESH_W-1:0]  cfgThresh,
  input  logic                 cfgInvert,
  input  logic                 cfgEdge,
  input  logic                 cntWe,
  input  logic [CNT_W-1:0]     cntWrData,
  input  logic [LANES-1:0]     laneValid,
  input  logic [LANES-1:0]     laneIsSnoop,
  input  logic [3*LANES-1:0]   laneOutcome,
  input  logic [2*LANES-1:0]   laneOrigin,
  output logic [CNT_W-1:0]     cntValue
);
  localparam int CW = $clog2(LANES + 1);

  logic                 cfgEnQ, cfgInvQ, cfgEdgeQ, prevCondQ;
  logic [7:0]           cfgSelQ, cfgMaskQ;
  logic [THRESH_W-1:0]  cfgThrQ;
  logic [CW-1:0]        matchCount;
  evt_pkg::cnt_strobe_t strobe;

  evt_control #(.LANES(LANES), .THRESH_W(THRESH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEnable(cfgEnable),
    .cfgEventSel(cfgEventSel), .cfgUnitMask(cfgUnitMask), .cfgThresh(cfgThresh),
    .cfgInvert(cfgInvert), .cfgEdge(cfgEdge), .cntWe(cntWe), .matchCount(matchCount),
    .enQ(cfgEnQ), .selQ(cfgSelQ), .maskQ(cfgMaskQ), .thrQ(cfgThrQ), .invQ(cfgInvQ),
    .edgeQ(cfgEdgeQ), .prevCondQ(prevCondQ), .strobe(strobe)
  );

  evt_datapath #(.LANES(LANES), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .evtSel(cfgSelQ), .unitMask(cfgMaskQ),
    .laneValid(laneValid), .laneIsSnoop(laneIsSnoop), .laneOutcome(laneOutcome),
    .laneOrigin(laneOrigin), .strobe(strobe), .wrData(cntWrData),
    .matchCount(matchCount), .cntValue(cntValue)
  );
endmodule

// File: rtl/evt_counter_checker.sv
module evt_counter_checker #(
  parameter int LANES    = 4,
  parameter int CNT_W    = 48,
  parameter int THRESH_W = 3,
  localparam int CW      = $clog2(LANES + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                cntWe,
  input logic [CNT_W-1:0]    cntWrData,
  input logic [CNT_W-1:0]    cntValue,
  input logic                cfgEnQ,
  input logic [7:0]          cfgSelQ,
  input logic [7:0]          cfgMaskQ,
  input logic [THRESH_W-1:0] cfgThrQ,
  input logic                cfgEdgeQ,
  input logic                prevCondQ,
  input logic [CW-1:0]       matchCount
);
  assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rstN)
    cntWe |=> cntValue == $past(cntWrData));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnQ && !cntWe) |=> $stable(cntValue));

  assert_raw_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    !cntWe |=> (cntValue - $past(cntValue)) <= CNT_W'(LANES));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgThrQ != '0 && !cntWe) |=> (cntValue - $past(cntValue)) <= CNT_W'(1));

  assert_edge_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEdgeQ && cfgThrQ != '0 && prevCondQ && !cntWe) |=> $stable(cntValue));

  assert_unknown_sel_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSelQ != 8'h34 && cfgSelQ != 8'h22) |-> matchCount == '0);

  assert_filter_only_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgSelQ == 8'h34 && cfgMaskQ[3:0] == 4'b0) |-> matchCount == '0);
endmodule

bind slice_event_counter evt_counter_checker #(
  .LANES(LANES), .CNT_W(CNT_W), .THRESH_W(THRESH_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cntWe(cntWe), .cntWrData(cntWrData), .cntValue(cntValue),
  .cfgEnQ(cfgEnQ), .cfgSelQ(cfgSelQ), .cfgMaskQ(cfgMaskQ), .cfgThrQ(cfgThrQ),
  .cfgEdgeQ(cfgEdgeQ), .prevCondQ(prevCondQ), .matchCount(matchCount)
);

// File: tb/test_slice_event_counter.sv
module test_slice_event_counter;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int CNT_W = 48;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgEnable = 0, cfgInvert = 0, cfgEdge = 0, cntWe = 0;
  logic [7:0] cfgEventSel = 0, cfgUnitMask = 0;
  logic [TW-1:0] cfgThresh = 0;
  logic [CNT_W-1:0] cntWrData = 0;
  logic [LANES-1:0] laneValid = 0, laneIsSnoop = 0;
  logic [3*LANES-1:0] laneOutcome = 0;
  logic [2*LANES-1:0] laneOrigin = 0;
  logic [CNT_W-1:0] cntValue;

  // bench-side model state
  logic mEn = 0, mInv = 0, mEdge = 0, mPrev = 0;
  logic [7:0] mSel = 0, mMask = 0;
  int mThr = 0;
  logic [CNT_W-1:0] expCnt = 0;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_event_counter #(.LANES(LANES), .CNT_W(CNT_W), .THRESH_W(TW)) i_slice_event_counter (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEnable(cfgEnable), .cfgEventSel(cfgEventSel),
    .cfgUnitMask(cfgUnitMask), .cfgThresh(cfgThresh), .cfgInvert(cfgInvert), .cfgEdge(cfgEdge),
    .cntWe(cntWe), .cntWrData(cntWrData), .laneValid(laneValid), .laneIsSnoop(laneIsSnoop),
    .laneOutcome(laneOutcome), .laneOrigin(laneOrigin), .cntValue(cntValue)
  );

  task automatic check(input bit ok, input string req, input logic [CNT_W-1:0] act,
                       input logic [CNT_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Match rules taken from R2, R3, R4, R5
  function automatic bit laneHit(input logic [7:0] sel, input logic [7:0] m, input bit v,
                                 input bit snp, input int oc, input int og);
    bit st, fo;
    if (!v) return 0;
    if (!snp && sel == 8'h34) begin
      st = (oc <= 3) && m[oc];
      fo = (m[7:4] == 0) || m[7] || (og <= 2 && m[4+og]);
      return st && fo;
    end
    if (snp && sel == 8'h22) begin
      st = (oc <= 4) && m[oc];
      fo = (m[7:5] == 0) || (og <= 2 && m[5+og]);
      return st && fo;
    end
    return 0;
  endfunction

  // One clock: model the edge from the driven inputs, then compare at the falling edge
  task automatic step(input string req);
    int cnt;
    bit cond, nPrev;
    logic [CNT_W-1:0] nxt;
    cnt = 0;
    for (int i = 0; i < LANES; i++)
      cnt += int'(laneHit(mSel, mMask, laneValid[i], laneIsSnoop[i],
                          int'(laneOutcome[3*i +: 3]), int'(laneOrigin[2*i +: 2])));
    cond = (mThr != 0) && ((cnt >= mThr) ^ mInv);
    if (cntWe) nxt = cntWrData;
    else if (mEn && mThr == 0) nxt = expCnt + CNT_W'(cnt);
    else if (mEn && (mEdge ? (cond && !mPrev) : cond)) nxt = expCnt + 1;
    else nxt = expCnt;
    nPrev = mEn && cond;
    @(posedge clk);
    expCnt = nxt;
    mPrev = nPrev;
    if (cfgWe) begin
      mEn = cfgEnable; mSel = cfgEventSel; mMask = cfgUnitMask;
      mThr = int'(cfgThresh); mInv = cfgInvert; mEdge = cfgEdge;
    end
    @(negedge clk);
    check(cntValue === expCnt, req, cntValue, expCnt);
    cfgWe = 0;
    cntWe = 0;
  endtask

  task automatic setCfg(input bit en, input logic [7:0] sel, input logic [7:0] m,
                        input int thr, input bit inv, input bit edg);
    cfgWe = 1; cfgEnable = en; cfgEventSel = sel; cfgUnitMask = m;
    cfgThresh = TW'(thr); cfgInvert = inv; cfgEdge = edg;
  endtask

  task automatic clearLanes();
    laneValid = '0; laneIsSnoop = '0; laneOutcome = '0; laneOrigin = '0;
  endtask

  // k lookup lanes reporting M with read origin
  task automatic hitLanes(input int k);
    clearLanes();
    for (int i = 0; i < LANES; i++) if (i < k) laneValid[i] = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int pat[16] = '{0, 1, 2, 3, 4, 4, 2, 0, 3, 3, 1, 4, 0, 0, 4, 1};
    logic [7:0] badSel[6] = '{8'h00, 8'h21, 8'h23, 8'h33, 8'h35, 8'hFF};
    // R1: reset state, events while in reset
    hitLanes(4);
    repeat (3) @(negedge clk);
    check(cntValue === '0, "R1", cntValue, '0);
    rstN = 1;
    // R1: after reset enable is low, events do not count
    for (int c = 0; c < 3; c++) step("R1");

    // R2 / R3: lookup sweep, every mask against every outcome and origin
    for (int m = 0; m < 256; m++) begin
      clearLanes();
      setCfg(1, 8'h34, 8'(m), 0, 0, 0);
      cntWe = 1; cntWrData = '0;
      step("R2");
      for (int oc = 0; oc < 4; oc++)
        for (int og = 0; og < 4; og++) begin
          int ln;
          clearLanes();
          ln = (oc + og) % LANES;
          laneValid[ln] = 1; laneOutcome[3*ln +: 3] = 3'(oc); laneOrigin[2*ln +: 2] = 2'(og);
          step((m[3:0] == 0) ? "R3" : "R2");
        end
    end

    // R4: snoop sweep over every mask, outcome and origin
    for (int m = 0; m < 256; m++) begin
      clearLanes();
      setCfg(1, 8'h22, 8'(m), 0, 0, 0);
      cntWe = 1; cntWrData = '0;
      step("R4");
      for (int oc = 0; oc < 8; oc++)
        for (int og = 0; og < 4; og++) begin
          int ln;
          clearLanes();
          ln = (oc + og) % LANES;
          laneValid[ln] = 1; laneIsSnoop[ln] = 1;
          laneOutcome[3*ln +: 3] = 3'(oc); laneOrigin[2*ln +: 2] = 2'(og);
          step("R4");
        end
    end

    // R5: unknown selects and class mismatch, all lanes valid
    for (int s = 0; s < 6; s++) begin
      clearLanes();
      setCfg(1, badSel[s], 8'hFF, 0, 0, 0);
      step("R5");
      laneValid = '1; laneIsSnoop = 4'b0101;
      step("R5");
    end
    clearLanes();
    setCfg(1, 8'h34, 8'hFF, 0, 0, 0);
    step("R5");
    laneIsSnoop = '1; laneValid = '1;
    step("R5");

    // R6..R9: every threshold, invert and edge setting against a count pattern
    for (int thr = 0; thr < 8; thr++)
      for (int inv = 0; inv < 2; inv++)
        for (int edg = 0; edg < 2; edg++) begin
          string tag;
          tag = (thr == 0) ? "R6" : (edg != 0) ? "R9" : (inv != 0) ? "R8" : "R7";
          clearLanes();
          setCfg(1, 8'h34, 8'h11, thr, inv[0], edg[0]);
          cntWe = 1; cntWrData = 48'h100;
          step(tag);
          for (int p = 0; p < 16; p++) begin
            hitLanes(pat[p]);
            step(tag);
          end
        end

    // R10: enable low, events present
    clearLanes();
    setCfg(0, 8'h34, 8'h01, 0, 0, 0);
    step("R10");
    for (int c = 0; c < 6; c++) begin hitLanes(c % 5); step("R10"); end

    // R11: write wins over an increment, then counting resumes
    clearLanes();
    setCfg(1, 8'h34, 8'h01, 0, 0, 0);
    step("R11");
    hitLanes(4);
    cntWe = 1; cntWrData = 48'h0123_4567_89AB;
    step("R11");
    step("R11");

    // R12: wrap at full scale
    hitLanes(0);
    cntWe = 1; cntWrData = '1;
    step("R12");
    hitLanes(1);
    step("R12");
    check(cntValue === '0, "R12", cntValue, '0);
    cntWe = 1; cntWrData = 48'hFFFF_FFFF_FFFE;
    hitLanes(0);
    step("R12");
    hitLanes(4);
    step("R12");

    // R13: the cycle of a config write still counts with the old settings
    hitLanes(4);
    setCfg(1, 8'h34, 8'h00, 0, 0, 0);
    step("R13");
    step("R13");
    setCfg(1, 8'h34, 8'h01, 2, 0, 1);
    step("R13");
    step("R13");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule